// File: doc/BRIEF.md
# FM Sound Register Stream Player

This block replays a stored register-dump command stream into an FM synthesis chip. A periodic tick, typically near 44.1 kHz, sets the pace. Software points the block at the first byte of the stream and pulses `start`. From then on, every tick either counts down a pending wait or runs a burst of commands. A burst continues until it reaches a wait command or the end marker. The byte position reached is kept, so the next burst carries on from there.

Stream bytes come through a byte-read memory port. The request side is valid/ready: `mem_req_valid` and `mem_req_addr` stay asserted and unchanged until the memory accepts them with `mem_req_ready`. Only one request is outstanding at a time. The block raises `mem_rsp_ready` only while it waits for that single response. The response must come at least one cycle after the request is accepted, and it is taken in the cycle where `mem_rsp_valid` and `mem_rsp_ready` are both high. Because the memory may hold off both the request and the response for as long as it likes, bursts stretch as needed.

Writes to the chip use a two-step bus. First an address strobe, then a data strobe, each followed by a fixed number of idle clocks. Both counts are parameters. A tick that arrives while a burst is still running is held, one deep, and served when the burst ends. A free-running counter records every tick.

Top module: `sndstream_player`

## Requirements
- R1: `tick_count` is zero after reset and increases by exactly one on every clock where `tick` is high, whether or not the player is running.
- R2: A `start` pulse while not running loads `start_addr` as the stream position, clears the wait count and sets `running` on the next clock. A `start` pulse while running has no effect. While not running, no memory request is issued and ticks cause no chip writes.
- R3: On a tick where the wait count is nonzero, the wait count drops by one and no stream byte is read.
- R4: Command byte 0x5A is followed by an address byte A and a data byte D. They produce a chip address strobe (`chip_we`=1, `chip_sel`=0, `chip_data`=A). The data strobe (`chip_we`=1, `chip_sel`=1, `chip_data`=D) comes exactly ADDR_WAIT+1 clocks later. At least DATA_WAIT idle clocks follow before the next strobe. The burst then continues with the next command.
- R5: Command byte 0x61 is followed by a low byte L and a high byte H. It sets the wait count to H*256+L and ends the burst. The following H*256+L ticks only count down; the tick after them resumes the stream.
- R6: Command byte 0x00 ends the stream and clears `running`.
- R7: Any other command byte is skipped as a single byte, with no parameter consumed and no chip write.
- R8: The stream position persists between ticks, so a burst resumes at the byte after the last one consumed.
- R9: The memory request holds `mem_req_valid` and `mem_req_addr` stable until it is accepted.
- R10: A tick arriving during a burst is held, one deep, and served as soon as the burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock pacing pulse |
| start | input | 1 | Begin playback at `start_addr` |
| start_addr | input | AW | First byte of the stream |
| running | output | 1 | Playback active |
| tick_count | output | TW | Free-running tick counter |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Byte address requested |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Player waiting for read data |
| mem_rsp_data | input | 8 | Read data byte |
| chip_we | output | 1 | Chip write strobe |
| chip_sel | output | 1 | 0 = address strobe, 1 = data strobe |
| chip_data | output | 8 | Chip bus value |

## Verification
The sharpest overlap is a new tick landing while a burst is still fetching bytes or driving chip strobes. The bench provokes it with a stream that holds several writes, then a zero-length wait, then a further write and the end marker. It sends a second tick a few clocks into the first burst. Because no tick follows, the final write and the return of `running` to low can only appear if the held tick was served. The same run also shows that tick counting carries on during the burst.

// File: rtl/sndp_pkg.sv
package sndp_pkg;
  localparam logic [7:0] OP_END   = 8'h00;
  localparam logic [7:0] OP_WRITE = 8'h5A;
  localparam logic [7:0] OP_WAIT  = 8'h61;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_P1, ST_P2, ST_CHIP
  } player_state_e;

  typedef enum logic [2:0] {
    W_IDLE, W_ADR, W_AWT, W_DAT, W_DWT
  } wr_phase_e;
endpackage

// File: rtl/sndp_tick_counter.sv
module sndp_tick_counter #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [TW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  assert_tick_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/sndp_fetch.sv
module sndp_fetch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] addr,
  output logic          busy,
  output logic          done,
  output logic [7:0]    byte_out,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [7:0]    rsp_data
);
  logic wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      wait_q    <= 1'b0;
    end else begin
      if (go && !busy) begin
        req_valid <= 1'b1;
        req_addr  <= addr;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        wait_q    <= 1'b1;
      end else if (wait_q && rsp_valid) begin
        wait_q <= 1'b0;
      end
    end
  end

  assign busy      = req_valid || wait_q;
  assign rsp_ready = wait_q;
  assign done      = wait_q && rsp_valid;
  assign byte_out  = rsp_data;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
endmodule

// File: rtl/sndp_chip_writer.sv
module sndp_chip_writer
  import sndp_pkg::*;
#(
  parameter int ADDR_WAIT = 4,
  parameter int DATA_WAIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] a_in,
  input  logic [7:0] d_in,
  output logic       done,
  output logic       chip_we,
  output logic       chip_sel,
  output logic [7:0] chip_data
);
  localparam int MAXW = (ADDR_WAIT > DATA_WAIT) ? ADDR_WAIT : DATA_WAIT;
  localparam int CW   = $clog2(MAXW + 1);

  wr_phase_e     ph;
  logic [CW-1:0] cnt;
  logic [7:0]    a_q, d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= W_IDLE;
      cnt <= '0;
      a_q <= '0;
      d_q <= '0;
    end else begin
      unique case (ph)
        W_IDLE: if (go) begin
          a_q <= a_in;
          d_q <= d_in;
          ph  <= W_ADR;
        end
        W_ADR: begin
          cnt <= '0;
          ph  <= W_AWT;
        end
        W_AWT: if (cnt == CW'(ADDR_WAIT - 1)) ph <= W_DAT;
               else cnt <= cnt + 1'b1;
        W_DAT: begin
          cnt <= '0;
          ph  <= W_DWT;
        end
        W_DWT: if (cnt == CW'(DATA_WAIT - 1)) ph <= W_IDLE;
               else cnt <= cnt + 1'b1;
        default: ph <= W_IDLE;
      endcase
    end
  end

  assign chip_we   = (ph == W_ADR) || (ph == W_DAT);
  assign chip_sel  = (ph == W_DAT);
  assign chip_data = (ph == W_DAT) ? d_q : (ph == W_ADR) ? a_q : 8'h00;
  assign done      = (ph == W_DWT) && (cnt == CW'(DATA_WAIT - 1));

  assert_addr_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_we && !chip_sel |=> !chip_we);
  assert_data_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_we && chip_sel |=> !chip_we);
endmodule

// File: rtl/sndstream_player.sv
module sndstream_player
  import sndp_pkg::*;
#(
  parameter int AW        = 16,
  parameter int TW        = 16,
  parameter int ADDR_WAIT = 4,
  parameter int DATA_WAIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          running,
  output logic [TW-1:0] tick_count,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [7:0]    mem_rsp_data,
  output logic          chip_we,
  output logic          chip_sel,
  output logic [7:0]    chip_data
);
  player_state_e st;
  logic [AW-1:0] ptr;
  logic [15:0]   delay_q;
  logic [7:0]    cmd_q, p1_q;
  logic          run_q, pend_q;
  logic          svc, fetching, f_busy, f_done, wr_go, wr_done;
  logic [7:0]    fbyte;

  assign svc      = run_q && (st == ST_IDLE) && (tick || pend_q);
  assign fetching = (st == ST_CMD) || (st == ST_P1) || (st == ST_P2);
  assign wr_go    = (st == ST_P2) && f_done && (cmd_q == OP_WRITE);
  assign running  = run_q;

  sndp_tick_counter #(.TW(TW)) i_ticks (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(tick_count));

  sndp_fetch #(.AW(AW)) i_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetching && !f_busy), .addr(ptr),
    .busy(f_busy), .done(f_done), .byte_out(fbyte),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_valid(mem_rsp_valid), .rsp_ready(mem_rsp_ready), .rsp_data(mem_rsp_data));

  sndp_chip_writer #(.ADDR_WAIT(ADDR_WAIT), .DATA_WAIT(DATA_WAIT)) i_wr (
    .clk(clk), .rst_n(rst_n), .go(wr_go), .a_in(p1_q), .d_in(fbyte),
    .done(wr_done), .chip_we(chip_we), .chip_sel(chip_sel), .chip_data(chip_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ptr     <= '0;
      delay_q <= '0;
      cmd_q   <= '0;
      p1_q    <= '0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (!run_q)   pend_q <= 1'b0;
      else if (svc) pend_q <= tick && pend_q;
      else          pend_q <= pend_q || tick;

      if (f_done) ptr <= ptr + 1'b1;

      unique case (st)
        ST_IDLE: begin
          if (!run_q) begin
            if (start) begin
              run_q   <= 1'b1;
              ptr     <= start_addr;
              delay_q <= '0;
            end
          end else if (svc) begin
            if (delay_q != '0) delay_q <= delay_q - 1'b1;
            else               st      <= ST_CMD;
          end
        end
        ST_CMD: if (f_done) begin
          cmd_q <= fbyte;
          if (fbyte == OP_END) begin
            run_q <= 1'b0;
            st    <= ST_IDLE;
          end else if (fbyte == OP_WRITE || fbyte == OP_WAIT) begin
            st <= ST_P1;
          end
        end
        ST_P1: if (f_done) begin
          p1_q <= fbyte;
          st   <= ST_P2;
        end
        ST_P2: if (f_done) begin
          if (cmd_q == OP_WAIT) begin
            delay_q <= {fbyte, p1_q};
            st      <= ST_IDLE;
          end else begin
            st <= ST_CHIP;
          end
        end
        ST_CHIP: if (wr_done) st <= ST_CMD;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_delay_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    svc && delay_q != '0 |=> delay_q == $past(delay_q) - 1'b1 && st == ST_IDLE && !mem_req_valid);
  assert_end_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_CMD && f_done && fbyte == OP_END |=> !running);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !mem_req_valid && !mem_rsp_ready);
  assert_wait_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_P2 && f_done && cmd_q == OP_WAIT |=> delay_q == {$past(fbyte), $past(p1_q)});
endmodule

// File: tb/test_sndstream_player.sv
module test_sndstream_player;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int TW = 16;
  localparam int AWT = 2;
  localparam int DWT = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic running, mem_req_valid, mem_rsp_ready, chip_we, chip_sel;
  logic mem_req_ready, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [7:0] mem_rsp_data, chip_data;
  logic [TW-1:0] tick_count;

  int checks = 0, failures = 0, cyc = 0, nticks = 0;
  logic [7:0] mem [256];
  int nw = 0, gapbad = 0, holdbad = 0, acyc = 0, dcyc = -100;
  logic [7:0] lat = '0;
  logic [7:0] wa [16];
  logic [7:0] wd [16];
  logic pv = 1'b0, pr = 1'b0;
  logic [AW-1:0] pa = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sndstream_player #(.AW(AW), .TW(TW), .ADDR_WAIT(AWT), .DATA_WAIT(DWT)) i_sndstream_player (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .start_addr(start_addr),
    .running(running), .tick_count(tick_count),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .chip_we(chip_we), .chip_sel(chip_sel), .chip_data(chip_data));

  assign mem_req_ready = (cyc % 3) != 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= 8'h00;
    end else begin
      if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr];
      end
      // R9 monitor: a stalled request must stay put
      if (pv && !pr && (!mem_req_valid || mem_req_addr != pa)) holdbad <= holdbad + 1;
      pv <= mem_req_valid; pr <= mem_req_ready; pa <= mem_req_addr;
      // R4 monitor: strobe spacing
      if (chip_we && !chip_sel) begin
        lat <= chip_data; acyc <= cyc;
        if (cyc - dcyc < DWT + 1) gapbad <= gapbad + 1;
      end
      if (chip_we && chip_sel) begin
        wa[nw % 16] <= lat; wd[nw % 16] <= chip_data; nw <= nw + 1; dcyc <= cyc;
        if (cyc - acyc != AWT + 1) gapbad <= gapbad + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1; nticks++;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_start(input logic [7:0] a);
    @(negedge clk) start = 1'b1; start_addr = a;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(tick_count == 0, "R1 reset count", int'(tick_count), 0);
    check(!running && !chip_we && !mem_req_valid, "R2 reset idle", int'(running), 0);

    base = nw;
    repeat (3) begin pulse_tick(); idle(2); end
    check(tick_count == 3, "R1 count while stopped", int'(tick_count), 3);
    check(nw == base && !running, "R2 ticks while stopped", nw - base, 0);

    mem[8'h10] = 8'h5A; mem[8'h11] = 8'h20; mem[8'h12] = 8'h41;
    mem[8'h13] = 8'h5A; mem[8'h14] = 8'h21; mem[8'h15] = 8'h42;
    mem[8'h16] = 8'h00;
    base = nw;
    do_start(8'h10);
    check(running, "R2 start sets running", int'(running), 1);
    pulse_tick(); idle(120);
    check(nw - base == 2, "R4 burst write count", nw - base, 2);
    check(wa[base % 16] == 8'h20 && wd[base % 16] == 8'h41, "R4 first pair", int'(wd[base % 16]), 'h41);
    check(wa[(base+1) % 16] == 8'h21 && wd[(base+1) % 16] == 8'h42, "R4 second pair", int'(wd[(base+1) % 16]), 'h42);
    check(!running, "R6 end marker", int'(running), 0);

    // R7: every unused code is skipped as one byte
    for (int c = 0; c < 256; c++) begin
      if (c == 8'h00 || c == 8'h5A || c == 8'h61) continue;
      mem[8'h40] = 8'(c); mem[8'h41] = 8'h5A; mem[8'h42] = 8'h01;
      mem[8'h43] = 8'(c); mem[8'h44] = 8'h00;
      base = nw;
      do_start(8'h40);
      pulse_tick(); idle(60);
      check(nw - base == 1 && wa[base % 16] == 8'h01 && wd[base % 16] == 8'(c) && !running,
            $sformatf("R7 skip code %0h", c), int'(wd[base % 16]), c);
    end

    // R3 R5 R8: wait command with several lengths, little-endian count
    foreach (mem[i]) if (i >= 8'h80 && i < 8'h88) mem[i] = 8'h00;
    for (int k = 0; k < 5; k++) begin
      int n;
      n = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 5 : 258;
      mem[8'h80] = 8'h61; mem[8'h81] = 8'(n & 255); mem[8'h82] = 8'(n >> 8);
      mem[8'h83] = 8'h5A; mem[8'h84] = 8'h30; mem[8'h85] = 8'(n & 255); mem[8'h86] = 8'h00;
      base = nw;
      do_start(8'h80);
      pulse_tick(); idle(40);
      check(running && nw == base, $sformatf("R5 wait %0d ends burst", n), nw - base, 0);
      do_start(8'h10);
      for (int t = 0; t < n; t++) begin pulse_tick(); idle(1); end
      idle(20);
      check(nw == base && running, $sformatf("R3 wait %0d holds", n), nw - base, 0);
      pulse_tick(); idle(60);
      check(nw - base == 1 && wa[base % 16] == 8'h30 && wd[base % 16] == 8'(n & 255),
            $sformatf("R8 resume after wait %0d", n), int'(wd[base % 16]), n & 255);
      check(!running, $sformatf("R6 stop after wait %0d", n), int'(running), 0);
    end

    // R10: tick during a burst is served afterwards
    mem[8'hA0] = 8'h5A; mem[8'hA1] = 8'h50; mem[8'hA2] = 8'h51;
    mem[8'hA3] = 8'h5A; mem[8'hA4] = 8'h52; mem[8'hA5] = 8'h53;
    mem[8'hA6] = 8'h61; mem[8'hA7] = 8'h00; mem[8'hA8] = 8'h00;
    mem[8'hA9] = 8'h5A; mem[8'hAA] = 8'h54; mem[8'hAB] = 8'h55;
    mem[8'hAC] = 8'h00;
    base = nw;
    do_start(8'hA0);
    pulse_tick(); idle(5);
    pulse_tick(); idle(200);
    check(nw - base == 3 && wa[(base+2) % 16] == 8'h54 && wd[(base+2) % 16] == 8'h55,
          "R10 held tick served", nw - base, 3);
    check(!running, "R10 stream finished", int'(running), 0);

    check(holdbad == 0, "R9 request held stable", holdbad, 0);
    check(gapbad == 0, "R4 strobe spacing", gapbad, 0);
    check(int'(tick_count) == nticks, "R1 total ticks", int'(tick_count), nticks);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule